// File: doc/BRIEF.md
# Execute-in-Place Exit and Software Reset Sequencer

This block runs on the host side of a serial flash link. It is used when the host controller has been reset and the flash memory has not, so the memory may still be in continuous-read (execute-in-place) mode and would misread the next command. A single start request makes the block send a fixed recovery series. First come six chip-select-low frames of rising length. In each one every data line is driven high, so the first dummy-cycle bit the memory samples is a 1 at any bus width, and that 1 ends execute-in-place. Each frame raises chip select before the clock edge that would follow its count. The block then sends two single-line command frames: reset-enable, then reset-memory.

The recovery frames do not abort a program or erase that may be running inside the memory. The software reset that follows is what returns the memory to its power-on state. The serial clock is made by dividing the system clock. The minimum chip-select-high time between frames comes from an input, so software can set it to the memory's timing. A busy level covers the whole series, and a one-cycle done pulse marks its end.

Top module: `xip_exit_seq`

## Requirements
- R1: After an accepted start, the block produces exactly eight chip-select-low frames in this order: 7, 9, 13, 17, 25 and 33 serial clock pulses, then 8 and 8.
- R2: The serial clock idles low and pulses only while chip select is low. Chip select falls HALF_DIV system cycles before the first rising clock edge of a frame. It rises HALF_DIV cycles after the last falling edge, with no further pulse. Each clock pulse is HALF_DIV cycles high and HALF_DIV cycles low.
- R3: Throughout each of the six exit frames, dq_o is 4'hF and dq_oe_o is 4'hF.
- R4: The seventh frame shifts opcode 0x66 and the eighth frame shifts opcode 0x99 on dq_o[0], most significant bit first, with dq_oe_o = 4'b0001. Each bit is set up while the clock is low and stays stable while it is high. dq_o[3:1] stay 1.
- R5: Between consecutive frames, chip select stays high for exactly max(gap_i, 1) system cycles. The same gap follows the last frame before completion.
- R6: busy_o rises in the cycle after an accepted start and falls after the final gap. done_o is high for exactly one cycle: the first cycle in which busy_o is low again.
- R7: A start request is accepted only when the block is idle. A start while busy_o is high has no effect on the frame series.
- R8: During and right after reset, cs_n_o = 1, sck_o = 0, dq_oe_o = 0, busy_o = 0 and done_o = 0.
- R9: Whenever chip select is high, dq_oe_o is 0 and dq_o reads 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the recovery series |
| gap_i | input | GAP_W | Minimum chip-select-high cycles between frames (0 treated as 1) |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Serial clock to the flash |
| dq_o | output | LANES | Data lines toward the flash |
| dq_oe_o | output | LANES | Per-lane output enable |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the edges of each frame. One extra pulse before chip select rises, or one too few, would leave a frame at 8 or 6 clocks, and the memory could then take it as a valid command. The opcode frames are checked bit by bit, because a shifter that is off by one would send 0xCC or 0x33 instead of the reset opcodes. A gap of zero must still give one high cycle, not merge two frames. A start held or repeated during the series must not restart the series or stretch it. The done pulse must fall in the single cycle in which busy drops, neither earlier nor twice.

// File: rtl/xip_exit_pkg.sv
package xip_exit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_e;

    localparam int NUM_FRAMES = 8;
    localparam int NUM_EXIT   = 6;
    localparam int IDX_W      = $clog2(NUM_FRAMES);
    localparam int PULSE_W    = 6;

    localparam logic [7:0] OPC_RESET_ARM = 8'h66;
    localparam logic [7:0] OPC_RESET_GO  = 8'h99;

    function automatic logic [PULSE_W-1:0] pulses_for(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    pulses_for = 6'd7;
            3'd1:    pulses_for = 6'd9;
            3'd2:    pulses_for = 6'd13;
            3'd3:    pulses_for = 6'd17;
            3'd4:    pulses_for = 6'd25;
            3'd5:    pulses_for = 6'd33;
            default: pulses_for = 6'd8;
        endcase
    endfunction

endpackage

// File: rtl/xip_exit_timer.sv
module xip_exit_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] len_i,
    output logic          last_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i - TW'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/xip_exit_frame_plan.sv
module xip_exit_frame_plan
    import xip_exit_pkg::*;
(
    input  logic [IDX_W-1:0]   idx_i,
    output logic [PULSE_W-1:0] pulses_o,
    output logic               is_cmd_o,
    output logic [7:0]         opcode_o,
    output logic               last_frame_o
);
    always_comb begin
        pulses_o     = pulses_for(idx_i);
        is_cmd_o     = (int'(idx_i) >= NUM_EXIT);
        opcode_o     = (int'(idx_i) == NUM_EXIT) ? OPC_RESET_ARM : OPC_RESET_GO;
        last_frame_o = (int'(idx_i) == NUM_FRAMES - 1);
    end
endmodule

// File: rtl/xip_exit_lane_drv.sv
module xip_exit_lane_drv #(
    parameter int LANES = 4
) (
    input  logic             active_i,
    input  logic             is_cmd_i,
    input  logic             bit_i,
    output logic [LANES-1:0] dq_o,
    output logic [LANES-1:0] oe_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_serial
            assign dq_o[g] = (active_i && is_cmd_i) ? bit_i : 1'b1;
            assign oe_o[g] = active_i;
        end else begin : g_wide
            assign dq_o[g] = 1'b1;
            assign oe_o[g] = active_i && !is_cmd_i;
        end
    end
endmodule

// File: rtl/xip_exit_seq.sv
module xip_exit_seq
    import xip_exit_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int GAP_W    = 8,
    parameter int LANES    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic [LANES-1:0] dq_o,
    output logic [LANES-1:0] dq_oe_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int HW = $clog2(HALF_DIV + 1);
    localparam int TW = (GAP_W > HW) ? GAP_W : HW;
    localparam logic [TW-1:0] HALF_LEN = TW'(HALF_DIV);

    typedef struct packed {
        seq_state_e         state;
        logic [IDX_W-1:0]   frame;
        logic [PULSE_W-1:0] pulses;
        logic               done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic               t_load;
    logic [TW-1:0]      t_len;
    logic               t_last;
    logic [PULSE_W-1:0] plan_pulses;
    logic               plan_cmd;
    logic [7:0]         plan_opc;
    logic               plan_last;
    logic [TW-1:0]      gap_eff;
    logic               in_frame;
    logic               ser_bit;

    xip_exit_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .len_i  (t_len),
        .last_o (t_last)
    );

    xip_exit_frame_plan u_plan (
        .idx_i        (r_q.frame),
        .pulses_o     (plan_pulses),
        .is_cmd_o     (plan_cmd),
        .opcode_o     (plan_opc),
        .last_frame_o (plan_last)
    );

    assign gap_eff = (gap_i == '0) ? TW'(1) : TW'(gap_i);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        t_load   = 1'b0;
        t_len    = HALF_LEN;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_SETUP;
                    r_d.frame  = '0;
                    r_d.pulses = '0;
                    t_load     = 1'b1;
                end
            end
            ST_SETUP: begin
                if (t_last) begin
                    r_d.state = ST_HIGH;
                    t_load    = 1'b1;
                end
            end
            ST_HIGH: begin
                if (t_last) begin
                    r_d.state  = ST_LOW;
                    r_d.pulses = r_q.pulses + PULSE_W'(1);
                    t_load     = 1'b1;
                end
            end
            ST_LOW: begin
                if (t_last) begin
                    t_load = 1'b1;
                    if (r_q.pulses == plan_pulses) begin
                        r_d.state = ST_GAP;
                        t_len     = gap_eff;
                    end else begin
                        r_d.state = ST_HIGH;
                    end
                end
            end
            ST_GAP: begin
                if (t_last) begin
                    if (plan_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state  = ST_SETUP;
                        r_d.frame  = r_q.frame + IDX_W'(1);
                        r_d.pulses = '0;
                        t_load     = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.frame  <= '0;
            r_q.pulses <= '0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_frame = (r_q.state == ST_SETUP) || (r_q.state == ST_HIGH) ||
                      (r_q.state == ST_LOW);
    assign ser_bit  = (r_q.pulses < PULSE_W'(8)) ?
                      plan_opc[3'd7 - r_q.pulses[2:0]] : 1'b1;

    xip_exit_lane_drv #(.LANES(LANES)) u_lanes (
        .active_i (in_frame),
        .is_cmd_i (plan_cmd),
        .bit_i    (ser_bit),
        .dq_o     (dq_o),
        .oe_o     (dq_oe_o)
    );

    assign cs_n_o = !in_frame;
    assign sck_o  = (r_q.state == ST_HIGH);
    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
endmodule

// File: rtl/xip_exit_seq_chk.sv
module xip_exit_seq_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cs_n_o,
    input logic             sck_o,
    input logic [LANES-1:0] dq_o,
    input logic [LANES-1:0] dq_oe_o,
    input logic             busy_o,
    input logic             done_o
);
    a_r2_clock_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);

    a_r9_lanes_released: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (dq_oe_o == '0));

    a_r3_exit_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && (&dq_oe_o)) |-> (&dq_o));

    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(dq_o));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_at_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    a_r6_busy_covers_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);

    a_r7_start_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !cs_n_o) |=> busy_o);
endmodule

bind xip_exit_seq xip_exit_seq_chk #(.LANES(LANES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cs_n_o  (cs_n_o),
    .sck_o   (sck_o),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/xip_exit_seq_bench.sv
`timescale 1ns/1ps
module xip_exit_seq_bench;
    localparam int HALF  = 2;
    localparam int GW    = 8;
    localparam int LN    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [GW-1:0] gap_i = 8'd3;
    logic          cs_n_o, sck_o, busy_o, done_o;
    logic [LN-1:0] dq_o, dq_oe_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xip_exit_seq #(.HALF_DIV(HALF), .GAP_W(GW), .LANES(LN)) u_xip_exit_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .gap_i(gap_i),
        .cs_n_o(cs_n_o), .sck_o(sck_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    // expected entry: phase(3) cs sck dq(4) oe(4) busy done ; phase 0 idle 1 exit 2 cmd 3 gap
    typedef struct packed {
        logic [2:0] ph;
        logic       cs, sck;
        logic [3:0] dq, oe;
        logic       busy, done;
    } exp_t;

    exp_t q[$];
    int   counts[8] = '{7, 9, 13, 17, 25, 33, 8, 8};
    bit   in_reset = 1;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic push(input logic [2:0] ph, input logic cs, input logic sck,
                        input logic [3:0] dq, input logic [3:0] oe, input logic busy, input logic done);
        exp_t e;
        e.ph = ph; e.cs = cs; e.sck = sck; e.dq = dq; e.oe = oe; e.busy = busy; e.done = done;
        q.push_back(e);
    endtask

    task automatic build(input int g);
        int ge = (g == 0) ? 1 : g;
        for (int f = 0; f < 8; f++) begin
            bit cmd = (f >= 6);
            logic [7:0] opc = (f == 6) ? 8'h66 : 8'h99;
            logic [3:0] oe = cmd ? 4'b0001 : 4'hF;
            logic [2:0] ph = cmd ? 3'd2 : 3'd1;
            for (int i = 0; i < HALF; i++)
                push(ph, 1'b0, 1'b0, cmd ? {3'b111, opc[7]} : 4'hF, oe, 1'b1, 1'b0);
            for (int k = 0; k < counts[f]; k++) begin
                logic b_hi = (k < 8) ? opc[7-k] : 1'b1;
                logic b_lo = (k + 1 < 8) ? opc[6-k] : 1'b1;
                for (int i = 0; i < HALF; i++)
                    push(ph, 1'b0, 1'b1, cmd ? {3'b111, b_hi} : 4'hF, oe, 1'b1, 1'b0);
                for (int i = 0; i < HALF; i++)
                    push(ph, 1'b0, 1'b0, cmd ? {3'b111, b_lo} : 4'hF, oe, 1'b1, 1'b0);
            end
            for (int i = 0; i < ge; i++)
                push(3'd3, 1'b1, 1'b0, 4'hF, 4'h0, 1'b1, 1'b0);
        end
        push(3'd0, 1'b1, 1'b0, 4'hF, 4'h0, 1'b0, 1'b1);
    endtask

    // independent frame monitor for R1 / R4
    int   mon_frame = 0;
    int   mon_pulses = 0;
    logic mon_prev_sck = 0;
    logic mon_prev_cs = 1;
    logic [7:0] mon_byte = 0;

    task automatic monitor();
        if (!cs_n_o && sck_o && !mon_prev_sck) begin
            mon_pulses++;
            mon_byte = {mon_byte[6:0], dq_o[0]};
        end
        if (cs_n_o && !mon_prev_cs) begin
            check("R1", "pulses in frame", mon_pulses, counts[mon_frame]);
            if (mon_frame == 6) check("R4", "reset-enable opcode", mon_byte, 8'h66);
            if (mon_frame == 7) check("R4", "reset-memory opcode", mon_byte, 8'h99);
            mon_frame = (mon_frame + 1) % 8;
            mon_pulses = 0;
            mon_byte = 0;
        end
        mon_prev_sck = sck_o;
        mon_prev_cs  = cs_n_o;
    endtask

    task automatic tick(input logic st, input logic [GW-1:0] g);
        exp_t e;
        string rq;
        @(negedge clk);
        if (finished) return;
        cyc++;
        if (q.size() > 0) e = q.pop_front();
        else begin
            e.ph = 3'd0; e.cs = 1'b1; e.sck = 1'b0; e.dq = 4'hF; e.oe = 4'h0; e.busy = 1'b0; e.done = 1'b0;
        end
        if (in_reset) rq = "R8";
        else case (e.ph)
            3'd1: rq = "R3";
            3'd2: rq = "R4";
            3'd3: rq = "R5";
            default: rq = "R9";
        endcase
        check(in_reset ? "R8" : (e.ph == 3'd3 ? "R5" : "R2"), "cs_n", cs_n_o, e.cs);
        check(in_reset ? "R8" : "R2", "sck", sck_o, e.sck);
        check(rq, "dq", dq_o, e.dq);
        check(rq, "dq_oe", dq_oe_o, e.oe);
        check(in_reset ? "R8" : (st && busy_o ? "R7" : "R6"), "busy", busy_o, e.busy);
        check(in_reset ? "R8" : "R6", "done", done_o, e.done);
        if (!in_reset) monitor();
        start_i = st;
        gap_i   = g;
        if (st && q.size() == 0 && !in_reset) build(int'(g));
    endtask

    task automatic run_to_idle(input logic [GW-1:0] g);
        int guard = 0;
        while (q.size() > 0 && guard < 5000 && !finished) begin
            tick(1'b0, g);
            guard++;
        end
        for (int i = 0; i < 4; i++) tick(1'b0, g);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state, start and gap applied are ignored while in reset
        for (int i = 0; i < 4; i++) tick(1'b0, 8'd3);
        @(negedge clk);
        rst_n = 1'b1;
        in_reset = 0;
        for (int i = 0; i < 3; i++) tick(1'b0, 8'd3);

        // run 1: gap 3, with start pulses during busy (R7)
        tick(1'b1, 8'd3);
        tick(1'b1, 8'd3);
        for (int i = 0; i < 100; i++) tick(1'b0, 8'd3);
        for (int i = 0; i < 3; i++) tick(1'b1, 8'd3);
        for (int i = 0; i < 200; i++) tick(1'b0, 8'd3);
        tick(1'b1, 8'd3);
        run_to_idle(8'd3);

        // run 2: gap 0 must act as one cycle (R5)
        tick(1'b1, 8'd0);
        run_to_idle(8'd0);

        // run 3: longer gap, restart right after done (R6)
        tick(1'b1, 8'd9);
        run_to_idle(8'd9);
        tick(1'b1, 8'd1);
        run_to_idle(8'd1);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule